// File: doc/BRIEF.md
# Programmable 50% Duty Clock Divider

This block takes a fast input clock and divides it by 3, 4, 5 or 6, chosen by a 2-bit code. The output has an exact 50% duty cycle for every ratio, including the odd ones. For an odd ratio, a phase timed on the rising edge is widened by half an input cycle. A copy of that phase, delayed by a flop on the falling edge, is ORed back in to do this. The divided clock feeds two identical differential pairs, each with a true and a complemented line.

The divide code comes from configuration logic that registers it on the input clock. The divider holds the code it is using for a whole output period. A new code therefore takes effect only at a period boundary, and no runt pulse is produced.

An active-high master reset clears the counter and phase flops at once. It forces every true line low and every complemented line high. Reset does not touch the code input. After release, the counter starts from zero, so the first rising output edge lands on the first input rising edge after reset falls.

Top module: `duty50_divider`

## Requirements
- R1: The division ratio follows the code on `div_code`: 2'b00 selects 3, 2'b01 selects 4, 2'b10 selects 5 and 2'b11 selects 6 input cycles per output period.
- R2: In each output period of N input cycles, the true output is high for exactly N input half-cycles, starting at the input rising edge that opens the period, and low for the remaining N half-cycles.
- R3: While `mr` is high, every bit of `out_p` is 0 and every bit of `out_n` is 1. This holds asynchronously, from the moment `mr` rises, whatever `div_code` does.
- R4: Both output pairs carry the same divided clock, and each `out_n` bit is the inverse of the matching `out_p` bit.
- R5: After `mr` falls, the first input rising edge opens the first output period: the true outputs go high there.
- R6: A code change seen partway through a period is applied only at the next period boundary. Any value the code takes and leaves within a period has no effect.
- R7: The ratio used for the first period after reset is the code presented at that first rising edge, even if the code changed while `mr` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | High-speed input clock to be divided |
| mr | input | 1 | Active-high master reset, asynchronous assertion |
| div_code | input | 2 | Divide-ratio select, registered on clk_in upstream |
| out_p | output | NUM_PAIRS (2) | True outputs of the pairs |
| out_n | output | NUM_PAIRS (2) | Complemented outputs of the pairs |

## Verification
The assertions assume that `div_code` changes only just after a rising edge of `clk_in`, as registered configuration logic would drive it. They also assume that `mr` falls away from a rising edge, so the counter never sees a half-released reset. The stimulus drives both the code and reset one nanosecond after a clock edge. It asserts `mr` in the middle of a period to exercise the asynchronous clear. Code changes are placed both inside a period and twice within one period, so that the boundary-only update is observed at the outputs.

// File: rtl/duty50_pkg.sv
`timescale 1ns/1ps
package duty50_pkg;

  // Ratio selected by a code: codes count upward from the base ratio.
  function automatic int ratio_of(input int code, input int base);
    return base + code;
  endfunction

  // Whole input cycles the rising-edge phase stays high in one period.
  function automatic int lead_cycles(input int ratio);
    return ratio / 2;
  endfunction

  // Odd ratios need the half-cycle stretch.
  function automatic bit needs_stretch(input int ratio);
    return (ratio % 2) == 1;
  endfunction

endpackage

// File: rtl/duty50_ratio_hold.sv
`timescale 1ns/1ps
module duty50_ratio_hold #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q
);

  // The code in use is only replaced at a period boundary (or in reset).
  always_ff @(posedge clk) begin
    if (load) begin
      code_q <= code_in;
    end
  end

  assert_code_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(code_q))
    else $error("code in use changed inside a period");

endmodule

// File: rtl/duty50_phase_gen.sv
`timescale 1ns/1ps
module duty50_phase_gen
  import duty50_pkg::*;
#(
  parameter int CODE_W     = 2,
  parameter int RATIO_BASE = 3,
  parameter int CNT_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code,
  output logic              wrap,
  output logic              lead_q
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] ratio_v;
  logic [CNT_W-1:0] half_v;
  logic             run_q;

  assign ratio_v = CNT_W'(ratio_of(int'(code), RATIO_BASE));
  assign half_v  = CNT_W'(lead_cycles(ratio_of(int'(code), RATIO_BASE)));

  // Period boundary: last count of the period, or first edge after reset.
  always_comb begin
    wrap    = !run_q || (cnt_q == ratio_v - CNT_W'(1));
    cnt_nxt = wrap ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q  <= '0;
      lead_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      lead_q <= (cnt_nxt < half_v);
      run_q  <= 1'b1;
    end
  end

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q < ratio_v))
    else $error("period counter beyond ratio");

  assert_period_open_R2: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (lead_q && cnt_q == '0))
    else $error("period did not open high");

  assert_first_edge_R5: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (run_q && lead_q))
    else $error("first edge after reset not high");

endmodule

// File: rtl/duty50_half_lag.sv
`timescale 1ns/1ps
module duty50_half_lag (
  input  logic clk,
  input  logic rst,
  input  logic lead_q,
  input  logic stretch,
  output logic div_clk
);

  logic lag_q;

  // Half-cycle delayed copy of the rising-edge phase.
  always_ff @(negedge clk or posedge rst) begin
    if (rst) begin
      lag_q <= 1'b0;
    end else begin
      lag_q <= lead_q;
    end
  end

  assign div_clk = stretch ? (lead_q | lag_q) : lead_q;

  assert_lag_follow_R2: assert property (@(posedge clk) disable iff (rst)
    lag_q == lead_q)
    else $error("falling-edge copy out of step");

endmodule

// File: rtl/duty50_divider.sv
`timescale 1ns/1ps
module duty50_divider
  import duty50_pkg::*;
#(
  parameter int CODE_W     = 2,
  parameter int RATIO_BASE = 3,
  parameter int NUM_PAIRS  = 2
) (
  input  logic                 clk_in,
  input  logic                 mr,
  input  logic [CODE_W-1:0]    div_code,
  output logic [NUM_PAIRS-1:0] out_p,
  output logic [NUM_PAIRS-1:0] out_n
);

  localparam int MAX_RATIO = ratio_of((2 ** CODE_W) - 1, RATIO_BASE);
  localparam int CNT_W     = $clog2(MAX_RATIO);

  logic              wrap;
  logic              lead_q;
  logic              stretch;
  logic              div_clk;
  logic [CODE_W-1:0] code_q;

  duty50_ratio_hold #(.CODE_W(CODE_W)) hold_i (
    .clk     (clk_in),
    .rst     (mr),
    .load    (wrap),
    .code_in (div_code),
    .code_q  (code_q)
  );

  duty50_phase_gen #(
    .CODE_W     (CODE_W),
    .RATIO_BASE (RATIO_BASE),
    .CNT_W      (CNT_W)
  ) phase_i (
    .clk    (clk_in),
    .rst    (mr),
    .code   (code_q),
    .wrap   (wrap),
    .lead_q (lead_q)
  );

  assign stretch = needs_stretch(ratio_of(int'(code_q), RATIO_BASE));

  duty50_half_lag lag_i (
    .clk     (clk_in),
    .rst     (mr),
    .lead_q  (lead_q),
    .stretch (stretch),
    .div_clk (div_clk)
  );

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign out_p[g] = div_clk;
    assign out_n[g] = ~div_clk;
  end

  always @(negedge clk_in) begin
    if (mr) begin
      assert_reset_level_R3: assert (out_p == '0 && out_n == '1)
        else $error("outputs not at reset level");
    end
  end

endmodule

// File: tb/duty50_divider_tb_top.sv
`timescale 1ns/100ps
module duty50_divider_tb_top;

  logic       clk = 1'b0;
  logic       mr  = 1'b0;
  logic [1:0] div_code = 2'b00;
  logic [1:0] out_p;
  logic [1:0] out_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_q[$];
  int seg_code[$];
  int seg_per[$];

  always #2 clk = ~clk;

  duty50_divider dut_i (
    .clk_in   (clk),
    .mr       (mr),
    .div_code (div_code),
    .out_p    (out_p),
    .out_n    (out_n)
  );

  // R1: ratio table restated as a lookup.
  function automatic int ref_ratio(input int c);
    case (c)
      0: return 3;
      1: return 4;
      2: return 5;
      default: return 6;
    endcase
  endfunction

  task automatic check_slot(input string tag, input bit e);
    logic [1:0] ep;
    logic [1:0] en;
    ep = {2{e}};
    en = ~ep;
    n_cmp++;
    if (out_p !== ep || out_n !== en) begin
      n_bad++;
      $display("FAIL %s t=%0t actual p=%b n=%b expected p=%b n=%b",
               tag, $time, out_p, out_n, ep, en);
    end
  endtask

  // R3: reset levels
  task automatic check_reset(input string tag);
    check_slot(tag, 1'b0);
  endtask

  // Scoreboard feed: 2N half-cycle slots per period, first N high (R2).
  task automatic push_expected();
    foreach (seg_code[i]) begin
      int n = ref_ratio(seg_code[i]);
      for (int p = 0; p < seg_per[i]; p++) begin
        for (int s = 0; s < 2 * n; s++) begin
          exp_q.push_back(s < n);
        end
      end
    end
  endtask

  // Driver: in the last period of each segment the next code is set,
  // first with a passing junk value (R6).
  task automatic drive_segments();
    foreach (seg_code[i]) begin
      int n = ref_ratio(seg_code[i]);
      int nxt = (i + 1 < seg_code.size()) ? seg_code[i+1] : seg_code[i];
      for (int p = 0; p < seg_per[i]; p++) begin
        @(posedge clk); #1;
        if (p == seg_per[i] - 1) begin
          div_code = 2'(nxt) ^ 2'b01;
          @(posedge clk); #1;
          div_code = 2'(nxt);
          repeat (n - 2) @(posedge clk);
        end else begin
          repeat (n - 1) @(posedge clk);
        end
      end
    end
  endtask

  task automatic monitor(input string tag);
    @(posedge clk);
    while (exp_q.size() > 0) begin
      bit e;
      #1;
      e = exp_q.pop_front();
      check_slot(tag, e);
      @(negedge clk); #1;
      e = exp_q.pop_front();
      check_slot(tag, e);
      @(posedge clk);
    end
  endtask

  task automatic run_segments(input string tag);
    push_expected();
    fork
      drive_segments();
      monitor(tag);
    join
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1 mr = 1'b1;
    #0.5;
    check_reset("R3 async entry");
    // R3: code toggles while in reset have no effect on outputs
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      div_code = 2'(k);
      check_reset("R3 hold");
    end

    // Main run: every code, mixed order (R1 R2 R4 R5 R6)
    div_code = 2'b00;
    seg_code = '{0, 1, 2, 3, 1, 3, 0, 2, 2};
    seg_per  = '{2, 2, 3, 2, 1, 1, 2, 1, 2};
    @(negedge clk); #1 mr = 1'b0;
    run_segments("R1/R2/R4/R5/R6");

    // Reset in the middle of a high phase (R3)
    @(posedge clk); #1 mr = 1'b1;
    #0.5;
    check_reset("R3 mid-period");
    // R7: code changed while reset is held
    div_code = 2'b11;
    @(negedge clk); #1;
    check_reset("R3 R7 during reset");
    div_code = 2'b10;
    @(negedge clk); #1;
    check_reset("R3 R7 during reset");

    seg_code = '{2, 0, 3};
    seg_per  = '{2, 2, 2};
    mr = 1'b0;
    run_segments("R7/R5/R1/R2/R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule